// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a 32-bit core and main memory as a direct-mapped data cache. Every store goes straight to memory, and a store that misses does not pull a line in. Each line holds a tag, a valid bit and a configurable number of words. Because no line can ever differ from memory, the design keeps no dirty state and never writes a line back when it evicts one.

The core issues one request at a time on a request/ready handshake. A request is accepted on a clock edge where both `core_req` and `core_ready` are high. Read data returns later on `core_rvalid`/`core_rdata`, and stores get no reply. Toward memory there are two interfaces. The first is a burst read: a one-cycle request with a line-aligned address, followed by one beat per word in increasing word order. The second is a single-word write that is held until memory acknowledges it. While a refill or a store to memory is in progress, `core_ready` stays low and the core's next request waits.

Addresses are word addresses. The low bits select the word within a line, the next bits select the line, and the remaining upper bits form the tag.

Top module: `wt_dcache`

## Requirements
- R1: Reset clears every valid bit. After reset, `core_ready` is 1, `core_rvalid` is 0, and neither memory request is asserted, so the first read of any address misses.
- R2: A word address splits into three fields: the low log2(WORDS) bits are the word offset, the next log2(LINES) bits are the line index, and the remaining upper bits are the tag. Lines at different indices never evict each other.
- R3: An accepted read that hits raises `core_rvalid` on the next cycle with the stored word. It causes no memory read and no memory write.
- R4: An accepted read that misses issues exactly one burst read. `mem_rd_req` is high for one cycle, and `mem_rd_addr` has its word-offset bits at zero. The miss causes no memory write.
- R5: Burst beats are written into the line in increasing word order starting at offset 0. After the refill, every word of the line reads back as a hit with the memory contents.
- R6: After a miss, the requested word is returned only once the whole line is stored and valid. `core_rvalid` rises in the second cycle after the final beat and is never high while a beat is being delivered.
- R7: A store that hits updates the cached word at acceptance and then performs one memory write with the same address and data. A later read of that word hits and returns the new data.
- R8: A store that misses performs one memory write and leaves the cache unchanged. A later read of that address misses and returns the new data from memory.
- R9: `mem_wr_req`, together with its address and data, stays asserted until `mem_wr_ack`. `core_ready` returns in the cycle after the acknowledge. A store never produces `core_rvalid`.
- R10: While a refill or a memory write is outstanding, `core_ready` is 0 and new core requests are held off.
- R11: A miss to a line index that already holds another tag replaces that line, so a later read of the old tag misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_req | input | 1 | Core request valid |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | ADDR_W | Word address of the request |
| core_wdata | input | DATA_W | Store data |
| core_ready | output | 1 | Cache can accept a request this cycle |
| core_rvalid | output | 1 | Load data valid, one cycle |
| core_rdata | output | DATA_W | Load data |
| mem_rd_req | output | 1 | One-cycle burst read request |
| mem_rd_addr | output | ADDR_W | Line-aligned burst start word address |
| mem_rd_valid | input | 1 | Burst beat valid |
| mem_rd_data | input | DATA_W | Burst beat data |
| mem_wr_req | output | 1 | Single-word write request, held until acknowledged |
| mem_wr_addr | output | ADDR_W | Write word address |
| mem_wr_data | output | DATA_W | Write data |
| mem_wr_ack | input | 1 | Write acknowledge, one cycle |

## Verification
The bound checker checks the following on every cycle:
- a load hit gives data on the next cycle with no memory traffic;
- a load miss raises a burst request;
- a store raises a memory write;
- memory writes stay held until acknowledged;
- burst addresses are line-aligned;
- `core_ready` is low whenever memory traffic is outstanding;
- no data is returned while a beat is being delivered.

The contents of the lines can only be shown by the bench's scenarios. These cover beat order, write-hit and write-miss effects on later reads, eviction on an index conflict, the index/tag split, and the loss of all lines on reset. The bench also checks the exact return cycle after a refill against its own beat timing.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_FILL,
        ST_RD_DONE,
        ST_WR_MEM
    } cache_state_e;

    typedef enum logic [1:0] {
        OP_LOAD_HIT,
        OP_LOAD_MISS,
        OP_STORE
    } cache_op_e;

    function automatic cache_op_e classify(input logic we, input logic hit);
        if (we)       return OP_STORE;
        else if (hit) return OP_LOAD_HIT;
        else          return OP_LOAD_MISS;
    endfunction

endpackage

// File: rtl/wt_dcache_tags.sv
module wt_dcache_tags #(
    parameter int LINES = 16,
    parameter int TAG_W = 26,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [TAG_W-1:0] tag_mem [LINES];
    logic [LINES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag   = tag_mem[rd_idx];
    assign rd_valid = valid_q[rd_idx];
endmodule

// File: rtl/wt_dcache_data.sv
module wt_dcache_data #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word_mem [LINES][WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            word_mem[wr_idx][wr_off] <= wr_data;
        end
    end

    assign rd_data = word_mem[rd_idx][rd_off];
endmodule

// File: rtl/wt_dcache_ctrl.sv
module wt_dcache_ctrl
    import wt_dcache_pkg::*;
#(
    parameter int WORDS = 4,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             core_req,
    input  logic             core_we,
    input  logic             hit,
    input  logic             mem_rd_valid,
    input  logic             mem_wr_ack,
    output cache_state_e     state,
    output logic [OFF_W-1:0] beat,
    output logic             last_beat,
    output logic             core_ready
);
    cache_state_e state_d;
    logic         accept;

    assign core_ready = (state == ST_IDLE);
    assign accept     = core_req && core_ready;
    assign last_beat  = (state == ST_RD_FILL) && mem_rd_valid
                        && (beat == OFF_W'(WORDS - 1));

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    unique case (classify(core_we, hit))
                        OP_STORE:     state_d = ST_WR_MEM;
                        OP_LOAD_MISS: state_d = ST_RD_ISSUE;
                        default:      state_d = ST_IDLE;
                    endcase
                end
            end
            ST_RD_ISSUE: state_d = ST_RD_FILL;
            ST_RD_FILL:  if (last_beat) state_d = ST_RD_DONE;
            ST_RD_DONE:  state_d = ST_IDLE;
            ST_WR_MEM:   if (mem_wr_ack) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            beat  <= '0;
        end else begin
            state <= state_d;
            if (state == ST_RD_ISSUE) begin
                beat <= '0;
            end else if (state == ST_RD_FILL && mem_rd_valid) begin
                beat <= beat + 1'b1;
            end
        end
    end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
    import wt_dcache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_req,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [DATA_W-1:0] core_wdata,
    output logic              core_ready,
    output logic              core_rvalid,
    output logic [DATA_W-1:0] core_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_req,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ack
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

    cache_state_e      state;
    logic [OFF_W-1:0]  beat;
    logic              last_beat;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;

    logic [ADDR_W-1:0] look_addr;
    logic [OFF_W-1:0]  look_off;
    logic [IDX_W-1:0]  look_idx;
    logic [TAG_W-1:0]  look_tag;
    logic [IDX_W-1:0]  held_idx;
    logic [TAG_W-1:0]  held_tag;

    logic [TAG_W-1:0]  tag_rd;
    logic              tag_valid;
    logic              lookup_hit;
    logic              accept;
    logic              store_hit;
    logic              fill_wr;

    logic              dat_wr_en;
    logic [IDX_W-1:0]  dat_wr_idx;
    logic [OFF_W-1:0]  dat_wr_off;
    logic [DATA_W-1:0] dat_wr_data;
    logic [DATA_W-1:0] dat_rd;

    // Field split: offset low, index next, tag on top
    assign look_addr = (state == ST_IDLE) ? core_addr : req_addr_q;
    assign look_off  = look_addr[OFF_W-1:0];
    assign look_idx  = look_addr[OFF_W +: IDX_W];
    assign look_tag  = look_addr[ADDR_W-1 -: TAG_W];
    assign held_idx  = req_addr_q[OFF_W +: IDX_W];
    assign held_tag  = req_addr_q[ADDR_W-1 -: TAG_W];

    assign lookup_hit = tag_valid && (tag_rd == look_tag);
    assign accept     = core_req && core_ready;
    assign store_hit  = accept && core_we && lookup_hit;
    assign fill_wr    = (state == ST_RD_FILL) && mem_rd_valid;

    wt_dcache_ctrl #(.WORDS(WORDS)) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .core_req     (core_req),
        .core_we      (core_we),
        .hit          (lookup_hit),
        .mem_rd_valid (mem_rd_valid),
        .mem_wr_ack   (mem_wr_ack),
        .state        (state),
        .beat         (beat),
        .last_beat    (last_beat),
        .core_ready   (core_ready)
    );

    wt_dcache_tags #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (look_idx),
        .rd_tag   (tag_rd),
        .rd_valid (tag_valid),
        .wr_en    (last_beat),
        .wr_idx   (held_idx),
        .wr_tag   (held_tag)
    );

    // Data array write port: refill beat or store hit
    always_comb begin
        if (fill_wr) begin
            dat_wr_en   = 1'b1;
            dat_wr_idx  = held_idx;
            dat_wr_off  = beat;
            dat_wr_data = mem_rd_data;
        end else begin
            dat_wr_en   = store_hit;
            dat_wr_idx  = look_idx;
            dat_wr_off  = look_off;
            dat_wr_data = core_wdata;
        end
    end

    wt_dcache_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) data_i (
        .clk     (clk),
        .wr_en   (dat_wr_en),
        .wr_idx  (dat_wr_idx),
        .wr_off  (dat_wr_off),
        .wr_data (dat_wr_data),
        .rd_idx  (look_idx),
        .rd_off  (look_off),
        .rd_data (dat_rd)
    );

    always_ff @(posedge clk) begin
        if (accept) begin
            req_addr_q  <= core_addr;
            req_wdata_q <= core_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_rvalid <= 1'b0;
            core_rdata  <= '0;
        end else begin
            core_rvalid <= (accept && !core_we && lookup_hit)
                           || (state == ST_RD_DONE);
            core_rdata  <= dat_rd;
        end
    end

    assign mem_rd_req  = (state == ST_RD_ISSUE);
    assign mem_rd_addr = {req_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mem_wr_req  = (state == ST_WR_MEM);
    assign mem_wr_addr = req_addr_q;
    assign mem_wr_data = req_wdata_q;
endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              core_req,
    input logic              core_we,
    input logic              core_ready,
    input logic              core_rvalid,
    input logic              hit,
    input logic              mem_rd_req,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_valid,
    input logic              mem_wr_req,
    input logic              mem_wr_ack
);
    // R3
    load_hit_fast_chk: assert property (@(posedge clk) disable iff (rst)
        core_req && core_ready && !core_we && hit
        |=> core_rvalid && !mem_rd_req && !mem_wr_req);

    // R4
    load_miss_burst_chk: assert property (@(posedge clk) disable iff (rst)
        core_req && core_ready && !core_we && !hit |=> mem_rd_req);

    // R4
    burst_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> (mem_rd_addr[OFF_W-1:0] == '0));

    // R4
    burst_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req);

    // R7
    store_writes_chk: assert property (@(posedge clk) disable iff (rst)
        core_req && core_ready && core_we |=> mem_wr_req);

    // R9
    write_held_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_req && !mem_wr_ack |=> mem_wr_req);

    // R4
    no_write_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !mem_wr_req);

    // R6
    no_data_during_beat_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |-> !core_rvalid);

    // R10
    stall_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req || mem_wr_req || mem_rd_valid) |-> !core_ready);
endmodule

bind wt_dcache wt_dcache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .core_req     (core_req),
    .core_we      (core_we),
    .core_ready   (core_ready),
    .core_rvalid  (core_rvalid),
    .hit          (lookup_hit),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_wr_req   (mem_wr_req),
    .mem_wr_ack   (mem_wr_ack)
);

// File: tb/wt_dcache_tb_top.sv
`timescale 1ns/1ps
module wt_dcache_tb_top;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LINES  = 8;
    localparam int WORDS  = 4;
    localparam int MEM_N  = 256;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              core_req = 1'b0;
    logic              core_we = 1'b0;
    logic [ADDR_W-1:0] core_addr = '0;
    logic [DATA_W-1:0] core_wdata = '0;
    logic              core_ready;
    logic              core_rvalid;
    logic [DATA_W-1:0] core_rdata;
    logic              mem_rd_req;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rd_valid = 1'b0;
    logic [DATA_W-1:0] mem_rd_data = '0;
    logic              mem_wr_req;
    logic [ADDR_W-1:0] mem_wr_addr;
    logic [DATA_W-1:0] mem_wr_data;
    logic              mem_wr_ack = 1'b0;

    always #5 clk = ~clk;

    wt_dcache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .WORDS(WORDS)) dut_i (
        .clk(clk), .rst(rst),
        .core_req(core_req), .core_we(core_we), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_ready(core_ready),
        .core_rvalid(core_rvalid), .core_rdata(core_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack)
    );

    int n_checks = 0;
    int n_fails  = 0;
    int n_bursts = 0;
    int n_writes = 0;
    int cyc = 0;
    int last_beat_cyc = 0;

    logic [DATA_W-1:0] mem_model [MEM_N];
    logic [DATA_W-1:0] exp_mem   [MEM_N];

    logic [DATA_W-1:0] exp_q [$];
    bit                miss_q [$];
    string             tag_q [$];

    function automatic logic [DATA_W-1:0] init_word(input int i);
        return {8'hA5, 8'(i), 16'(i * 37 + 5)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: burst reads
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && mem_rd_req) begin
                int base;
                base = int'(mem_rd_addr);
                n_bursts++;
                chk(mem_rd_addr[1:0] == 2'b00, "R4 burst alignment",
                    mem_rd_addr, {mem_rd_addr[31:2], 2'b00});
                repeat (2) @(posedge clk);
                for (int b = 0; b < WORDS; b++) begin
                    mem_rd_valid <= 1'b1;
                    mem_rd_data  <= mem_model[(base + b) % MEM_N];
                    @(posedge clk);
                end
                mem_rd_valid <= 1'b0;
            end
        end
    end

    // Memory model: single-word writes, acknowledged after one wait cycle
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && mem_wr_req && !mem_wr_ack) begin
                @(posedge clk);
                mem_wr_ack <= 1'b1;
                mem_model[int'(mem_wr_addr) % MEM_N] <= mem_wr_data;
                n_writes++;
                @(posedge clk);
                mem_wr_ack <= 1'b0;
            end
        end
    end

    // Monitor: pops the scoreboard as load data appears
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (mem_rd_valid) last_beat_cyc = cyc;
                if (core_rvalid) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected load data", core_rdata, 32'h0);
                    end else begin
                        logic [DATA_W-1:0] e;
                        bit m;
                        string t;
                        e = exp_q.pop_front();
                        m = miss_q.pop_front();
                        t = tag_q.pop_front();
                        chk(core_rdata == e, t, core_rdata, e);
                        if (m)
                            chk(cyc == last_beat_cyc + 2, "R6 return cycle after refill",
                                32'(cyc), 32'(last_beat_cyc + 2));
                    end
                end
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        core_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_read(input int addr, input bit exp_miss, input string tag);
        int b0, w0;
        b0 = n_bursts;
        w0 = n_writes;
        exp_q.push_back(exp_mem[addr]);
        miss_q.push_back(exp_miss);
        tag_q.push_back(tag);
        @(negedge clk);
        core_req  = 1'b1;
        core_we   = 1'b0;
        core_addr = ADDR_W'(addr);
        while (!core_ready) @(negedge clk);
        @(negedge clk);
        core_req = 1'b0;
        if (exp_miss) begin
            chk(!core_ready, "R10 stall during refill", 32'(core_ready), 32'h0);
            chk(!core_rvalid, "R6 no early data on miss", 32'(core_rvalid), 32'h0);
        end else begin
            chk(core_rvalid, "R3 hit data next cycle", 32'(core_rvalid), 32'h1);
        end
        while (exp_q.size() != 0) @(negedge clk);
        chk(n_bursts - b0 == int'(exp_miss), {tag, " burst count"},
            32'(n_bursts - b0), 32'(exp_miss));
        chk(n_writes == w0, {tag, " no memory write on load"},
            32'(n_writes - w0), 32'h0);
    endtask

    task automatic do_write(input int addr, input logic [DATA_W-1:0] data,
                            input string tag);
        int b0, w0;
        b0 = n_bursts;
        w0 = n_writes;
        exp_mem[addr] = data;
        @(negedge clk);
        core_req   = 1'b1;
        core_we    = 1'b1;
        core_addr  = ADDR_W'(addr);
        core_wdata = data;
        while (!core_ready) @(negedge clk);
        @(negedge clk);
        core_req = 1'b0;
        core_we  = 1'b0;
        chk(!core_ready, "R10 stall during write", 32'(core_ready), 32'h0);
        while (!core_ready) @(negedge clk);
        chk(n_writes - w0 == 1, {tag, " one memory write"}, 32'(n_writes - w0), 32'h1);
        chk(n_bursts == b0, {tag, " no burst on store"}, 32'(n_bursts - b0), 32'h0);
        chk(mem_model[addr] == data, {tag, " memory updated"}, mem_model[addr], data);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'(cyc), 32'h0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            mem_model[i] = init_word(i);
            exp_mem[i]   = init_word(i);
        end
        do_reset();
        @(negedge clk);
        chk(core_ready, "R1 ready after reset", 32'(core_ready), 32'h1);
        chk(!core_rvalid, "R1 no rvalid after reset", 32'(core_rvalid), 32'h0);
        chk(!mem_rd_req && !mem_wr_req, "R1 no memory request after reset",
            32'({mem_rd_req, mem_wr_req}), 32'h0);

        // Index 4 (addr 0x10): miss, then other words of the line hit
        do_read(32'h10, 1'b1, "R4 first read misses");
        do_read(32'h13, 1'b0, "R5 last word of refilled line");
        do_read(32'h11, 1'b0, "R5 middle word of refilled line");
        do_read(32'h10, 1'b0, "R3 repeat hit");

        // Store hit then read back
        do_write(32'h12, 32'hDEAD_BEEF, "R7 store hit");
        do_read(32'h12, 1'b0, "R7 read after store hit");

        // Store miss: cache untouched, next read misses and sees new data
        do_write(32'h40, 32'h1234_5678, "R8 store miss");
        do_read(32'h40, 1'b1, "R8 read after store miss");

        // Index conflict: 0x30 shares index 4 with 0x10
        do_read(32'h30, 1'b1, "R11 conflicting line fill");
        do_read(32'h10, 1'b1, "R11 evicted line misses");
        do_read(32'h12, 1'b0, "R7 stored word survives refill");
        do_read(32'h31, 1'b1, "R11 second eviction");

        // Reset loses every line
        do_reset();
        do_read(32'h31, 1'b1, "R1 miss after reset");

        // Different index keeps both lines
        do_read(32'h14, 1'b1, "R2 new index misses");
        do_read(32'h32, 1'b0, "R2 other index not evicted");
        do_read(32'h17, 1'b0, "R2 offset within index 5");

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule